// File: doc/BRIEF.md
# Floating-Point Status Register Commit Unit

This block holds the floating-point status register and, in the cycle in which a floating-point operation finishes, decides which of its effects become architecturally visible. The execution unit presents the operation's exception flags, an optional two-bit condition-code result, a class code for any trap that execution itself raised, and a valid strobe. The block applies the trap-enable mask and derives the underflow flag according to whether underflow is trapped. From that it decides whether a trap is taken. In the same cycle it drives the destination-register write enable, the condition-code write enable and the trap request. The register fields update on the following clock edge.

A trap of any kind holds back the destination write, the condition codes and the accrued exceptions. A trap caused by an enabled IEEE exception still loads the current-exception field with the exceptions that caused it, so that a handler can read them. Traps for unfinished or unimplemented operations leave that field alone. Software can rewrite the register through a write port. That port cannot change the version field or the trap-type field.

Top module: `fpsr_commit`

## Requirements
- R1: While rstN is low, every bit of fsr is 0 except the version field, which holds the configured version, and rdWe, ccWe and trapReq are 0.
- R2: fsr layout: rounding mode [31:30], trap enables [27:23], version [19:17], trap type [16:14], condition codes [11:10], accrued exceptions [9:5], current exceptions [4:0]; bits 29:28, 22:20 and 13:12 read 0. Within each 5-bit exception field the bit order is invalid [4], overflow [3], underflow [2], divide-by-zero [1], inexact [0]. On opFlags, bit 2 means "result is tiny".
- R3: When an operation commits without a trap, rdWe (opHasCc=0) or ccWe (opHasCc=1) is high in the opValid cycle. On the next edge, the current field takes the effective flags, the accrued field ORs them in, the condition codes take opCc if opHasCc=1, and the trap type becomes 0.
- R4: With the underflow enable (bit 25) clear, the effective underflow flag is set only when opFlags marks the result both tiny and inexact.
- R5: With the underflow enable set, a tiny result alone sets the effective underflow flag and causes an IEEE trap.
- R6: An IEEE trap is taken when the bitwise AND of the effective flags and the trap enables is nonzero. trapReq is then high, the trap type becomes 1, and the current field is loaded with that AND.
- R7: When any trap is taken, rdWe and ccWe stay 0, and the condition codes and the accrued field keep their values.
- R8: trapClass 2 (unfinished) or 3 (unimplemented) raises trapReq and sets the trap type to 2 or 3. It takes priority over an IEEE trap and leaves the current field unchanged. trapClass 1 is treated as 0.
- R9: When swWrite is high, swData loads rounding mode, trap enables, condition codes, accrued and current fields. The version, trap type and reserved bits ignore swData. Where an operation commits in the same cycle, the software write wins these fields, and the trap type still follows the operation.
- R10: The version field never changes. It reads 6 when PROTOTYPE is 1 and PROD_VERSION otherwise (default 0).
- R11: With opValid low, rdWe, ccWe and trapReq are 0, and the register changes only through swWrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation completes this cycle |
| opFlags | input | 5 | Raw exception flags from execution (bit 2 = tiny) |
| opHasCc | input | 1 | Operation is a compare producing condition codes |
| opCc | input | 2 | Condition-code result |
| trapClass | input | 2 | Execution trap class: 0 none, 2 unfinished, 3 unimplemented |
| swWrite | input | 1 | Software write strobe |
| swData | input | 32 | Software write data |
| fsr | output | 32 | Status register contents |
| rdWe | output | 1 | Destination register write enable |
| ccWe | output | 1 | Condition-code write enable |
| trapReq | output | 1 | Trap request |

## Verification
The embedded properties watch several things on every cycle. A trap never coexists with a destination or condition-code write. The accrued field keeps its value across a trap and only gains bits between software writes. The version field never moves. An unfinished or unimplemented class always traps and keeps the current field. Only the bench's scenarios can show the values involved: the underflow rule under both enable settings, the exact contents loaded into the current field on an IEEE trap, the trap-type codes, and which fields a software write can reach, including one that collides with a committing operation.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int FLAG_W = 5;
  localparam int CC_W   = 2;
  localparam int RM_W   = 2;
  localparam int VER_W  = 3;
  localparam int TT_W   = 3;
  localparam int REG_W  = 32;

  // Bit positions inside every exception field
  localparam int FLAG_NV = 4;
  localparam int FLAG_OF = 3;
  localparam int FLAG_UF = 2;
  localparam int FLAG_DZ = 1;
  localparam int FLAG_NX = 0;

  // Field positions inside the register
  localparam int RM_LSB   = 30;
  localparam int TEM_LSB  = 23;
  localparam int VER_LSB  = 17;
  localparam int TT_LSB   = 14;
  localparam int CC_LSB   = 10;
  localparam int AEXC_LSB = 5;
  localparam int CEXC_LSB = 0;

  typedef enum logic [1:0] {
    TC_NONE  = 2'd0,
    TC_RSVD  = 2'd1,
    TC_UNFIN = 2'd2,
    TC_UNIMP = 2'd3
  } trap_class_e;

  localparam logic [TT_W-1:0] TT_NONE = 3'd0;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

  typedef struct packed {
    logic            swLoad;
    logic            commit;
    logic            ccLoad;
    logic            cexcTrapLoad;
    logic            ttLoad;
    logic [TT_W-1:0] ttCode;
  } strobe_t;
endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic              opHasCc,
  input  logic [1:0]        trapClass,
  input  logic              swWrite,
  input  logic [FLAG_W-1:0] tem,
  output strobe_t           strobes,
  output logic [FLAG_W-1:0] effFlags,
  output logic [FLAG_W-1:0] trapFlags,
  output logic              rdWe,
  output logic              ccWe,
  output logic              trapReq
);
  logic hostTrap;
  logic ieeeTrap;
  logic anyTrap;

  always_comb begin
    effFlags          = opFlags;
    // untrapped underflow needs tiny and inexact; trapped needs tiny only
    effFlags[FLAG_UF] = opFlags[FLAG_UF] & (tem[FLAG_UF] | opFlags[FLAG_NX]);
    trapFlags         = effFlags & tem;
    hostTrap          = (trapClass == TC_UNFIN) || (trapClass == TC_UNIMP);
    ieeeTrap          = !hostTrap && (|trapFlags);
    anyTrap           = opValid && (hostTrap || ieeeTrap);

    rdWe    = opValid && !anyTrap && !opHasCc;
    ccWe    = opValid && !anyTrap && opHasCc;
    trapReq = anyTrap;

    strobes.swLoad       = swWrite;
    strobes.commit       = opValid && !anyTrap && !swWrite;
    strobes.ccLoad       = opValid && !anyTrap && !swWrite && opHasCc;
    strobes.cexcTrapLoad = opValid && ieeeTrap && !swWrite;
    strobes.ttLoad       = opValid;
    if (hostTrap)      strobes.ttCode = {1'b0, trapClass};
    else if (ieeeTrap) strobes.ttCode = TT_IEEE;
    else               strobes.ttCode = TT_NONE;
  end

  p_trap_blocks_writes_r7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (!rdWe && !ccWe));

  p_host_trap_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && trapClass[1]) |-> trapReq);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!rdWe && !ccWe && !trapReq));
endmodule

// File: rtl/fpsr_datapath.sv
module fpsr_datapath
  import fpsr_pkg::*;
#(
  parameter bit              PROTOTYPE    = 1'b0,
  parameter logic [VER_W-1:0] PROD_VERSION = 3'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [REG_W-1:0]  swData,
  input  logic [FLAG_W-1:0] effFlags,
  input  logic [FLAG_W-1:0] trapFlags,
  input  logic [CC_W-1:0]   opCc,
  output logic [REG_W-1:0]  fsr,
  output logic [FLAG_W-1:0] tem
);
  logic [RM_W-1:0]   rmQ;
  logic [FLAG_W-1:0] temQ;
  logic [TT_W-1:0]   ttQ;
  logic [CC_W-1:0]   ccQ;
  logic [FLAG_W-1:0] aexcQ;
  logic [FLAG_W-1:0] cexcQ;
  logic [VER_W-1:0]  verVal;

  generate
    if (PROTOTYPE) begin : g_proto
      assign verVal = 3'd6;
    end else begin : g_prod
      assign verVal = PROD_VERSION;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rmQ   <= '0;
      temQ  <= '0;
      ttQ   <= '0;
      ccQ   <= '0;
      aexcQ <= '0;
      cexcQ <= '0;
    end else begin
      if (strobes.swLoad) begin
        rmQ   <= swData[RM_LSB   +: RM_W];
        temQ  <= swData[TEM_LSB  +: FLAG_W];
        ccQ   <= swData[CC_LSB   +: CC_W];
        aexcQ <= swData[AEXC_LSB +: FLAG_W];
        cexcQ <= swData[CEXC_LSB +: FLAG_W];
      end else if (strobes.commit) begin
        cexcQ <= effFlags;
        aexcQ <= aexcQ | effFlags;
        if (strobes.ccLoad) ccQ <= opCc;
      end else if (strobes.cexcTrapLoad) begin
        cexcQ <= trapFlags;
      end
      if (strobes.ttLoad) ttQ <= strobes.ttCode;
    end
  end

  always_comb begin
    fsr = '0;
    fsr[RM_LSB   +: RM_W]   = rmQ;
    fsr[TEM_LSB  +: FLAG_W] = temQ;
    fsr[VER_LSB  +: VER_W]  = verVal;
    fsr[TT_LSB   +: TT_W]   = ttQ;
    fsr[CC_LSB   +: CC_W]   = ccQ;
    fsr[AEXC_LSB +: FLAG_W] = aexcQ;
    fsr[CEXC_LSB +: FLAG_W] = cexcQ;
  end

  assign tem = temQ;

  p_accrued_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.swLoad |=> ((aexcQ & $past(aexcQ)) == $past(aexcQ)));

  p_version_fixed_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(fsr[VER_LSB +: VER_W]));
endmodule

// File: rtl/fpsr_commit.sv
module fpsr_commit
  import fpsr_pkg::*;
#(
  parameter bit               PROTOTYPE    = 1'b0,
  parameter logic [VER_W-1:0] PROD_VERSION = 3'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic              opHasCc,
  input  logic [CC_W-1:0]   opCc,
  input  logic [1:0]        trapClass,
  input  logic              swWrite,
  input  logic [REG_W-1:0]  swData,
  output logic [REG_W-1:0]  fsr,
  output logic              rdWe,
  output logic              ccWe,
  output logic              trapReq
);
  strobe_t           strobes;
  logic [FLAG_W-1:0] effFlags;
  logic [FLAG_W-1:0] trapFlags;
  logic [FLAG_W-1:0] tem;

  fpsr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opFlags   (opFlags),
    .opHasCc   (opHasCc),
    .trapClass (trapClass),
    .swWrite   (swWrite),
    .tem       (tem),
    .strobes   (strobes),
    .effFlags  (effFlags),
    .trapFlags (trapFlags),
    .rdWe      (rdWe),
    .ccWe      (ccWe),
    .trapReq   (trapReq)
  );

  fpsr_datapath #(
    .PROTOTYPE    (PROTOTYPE),
    .PROD_VERSION (PROD_VERSION)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .swData    (swData),
    .effFlags  (effFlags),
    .trapFlags (trapFlags),
    .opCc      (opCc),
    .fsr       (fsr),
    .tem       (tem)
  );

  p_trap_keeps_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !swWrite) |=> ($stable(fsr[AEXC_LSB +: FLAG_W]) && $stable(fsr[CC_LSB +: CC_W])));

  p_host_trap_keeps_cexc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && trapClass[1] && !swWrite) |=> $stable(fsr[CEXC_LSB +: FLAG_W]));
endmodule

// File: tb/fpsr_commit_test.sv
`timescale 1ns/1ps
module fpsr_commit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opFlags = '0;
  logic        opHasCc = 1'b0;
  logic [1:0]  opCc = '0;
  logic [1:0]  trapClass = '0;
  logic        swWrite = 1'b0;
  logic [31:0] swData = '0;
  logic [31:0] fsr;
  logic        rdWe, ccWe, trapReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference state
  logic [1:0] mRm = '0;
  logic [4:0] mTem = '0;
  logic [2:0] mTt = '0;
  logic [1:0] mCc = '0;
  logic [4:0] mAexc = '0;
  logic [4:0] mCexc = '0;
  localparam logic [2:0] VER = 3'd0;

  always #2.5 clk = ~clk;

  fpsr_commit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opFlags(opFlags),
    .opHasCc(opHasCc), .opCc(opCc), .trapClass(trapClass),
    .swWrite(swWrite), .swData(swData), .fsr(fsr),
    .rdWe(rdWe), .ccWe(ccWe), .trapReq(trapReq)
  );

  function automatic logic [31:0] modelFsr();
    return {mRm, 2'b00, mTem, 3'b000, VER, mTt, 2'b00, mCc, mAexc, mCexc};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, compare outputs against the model, then advance the model.
  task automatic doCycle(input logic v, input logic [4:0] fl, input logic hc, input logic [1:0] cc,
                         input logic [1:0] tc, input logic sw, input logic [31:0] sd, input string tag);
    logic [4:0] eff, masked;
    logic trap;
    logic [2:0] code;
    opValid = v; opFlags = fl; opHasCc = hc; opCc = cc; trapClass = tc; swWrite = sw; swData = sd;
    #1;
    eff = fl;
    eff[2] = fl[2] && (mTem[2] || fl[0]);
    masked = eff & mTem;
    trap = 1'b0; code = 3'd0;
    if (tc == 2'd2 || tc == 2'd3) begin trap = 1'b1; code = {1'b0, tc}; end
    else if (masked != 5'd0) begin trap = 1'b1; code = 3'd1; end
    check(tag, "fsr",     fsr,            modelFsr());
    check(tag, "rdWe",    {31'd0, rdWe},    {31'd0, v && !trap && !hc});
    check(tag, "ccWe",    {31'd0, ccWe},    {31'd0, v && !trap && hc});
    check(tag, "trapReq", {31'd0, trapReq}, {31'd0, v && trap});
    @(posedge clk);
    if (sw) begin
      mRm = sd[31:30]; mTem = sd[27:23]; mCc = sd[11:10]; mAexc = sd[9:5]; mCexc = sd[4:0];
    end else if (v) begin
      if (!trap) begin
        mCexc = eff; mAexc = mAexc | eff;
        if (hc) mCc = cc;
      end else if (code == 3'd1) begin
        mCexc = masked;
      end
    end
    if (v) mTt = code;
    @(negedge clk);
  endtask

  function automatic logic [31:0] swWord(input logic [1:0] rm, input logic [4:0] te,
                                         input logic [1:0] cc, input logic [4:0] ae, input logic [4:0] ce);
    return {rm, 2'b11, te, 3'b111, 3'b101, 3'b111, 2'b11, cc, ae, ce};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fsr at reset", fsr, {12'd0, VER, 17'd0});
    check("R1", "outputs at reset", {29'd0, rdWe, ccWe, trapReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R11: idle
    doCycle(0, 5'h1f, 0, 2'd3, 2'd0, 0, 32'd0, "R11");
    // R3 / R2: untrapped commits, flag order invalid..inexact
    doCycle(1, 5'b10001, 0, 2'd0, 2'd0, 0, 32'd0, "R3");
    doCycle(1, 5'b01000, 0, 2'd0, 2'd0, 0, 32'd0, "R2");
    doCycle(1, 5'b00000, 1, 2'd2, 2'd0, 0, 32'd0, "R3");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R3");
    // R4: underflow untrapped
    doCycle(1, 5'b00100, 0, 2'd0, 2'd0, 0, 32'd0, "R4");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R4");
    doCycle(1, 5'b00101, 0, 2'd0, 2'd0, 0, 32'd0, "R4");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R4");
    // R9: software write, attempt on version/trap-type/reserved bits
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 1, swWord(2'd2, 5'b00100, 2'd1, 5'b00000, 5'b00000), "R9");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R10");
    // R5: trapped underflow on tiny alone
    doCycle(1, 5'b00100, 0, 2'd0, 2'd0, 0, 32'd0, "R5");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R5");
    // R6: overflow enabled trap, cexc gets only masked flags
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 1, swWord(2'd0, 5'b01000, 2'd0, 5'b00001, 5'b00000), "R9");
    doCycle(1, 5'b01001, 1, 2'd3, 2'd0, 0, 32'd0, "R6");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R7");
    // R8: unfinished and unimplemented, priority over IEEE
    doCycle(1, 5'b01000, 0, 2'd0, 2'd2, 0, 32'd0, "R8");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R8");
    doCycle(1, 5'b10000, 1, 2'd1, 2'd3, 0, 32'd0, "R8");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R7");
    doCycle(1, 5'b00001, 0, 2'd0, 2'd1, 0, 32'd0, "R8");
    // R9: write collides with a committing operation
    doCycle(1, 5'b10000, 1, 2'd2, 2'd0, 1, swWord(2'd1, 5'b00000, 2'd0, 5'b00000, 5'b00010), "R9");
    doCycle(1, 5'b00010, 0, 2'd0, 2'd3, 1, swWord(2'd3, 5'b00010, 2'd3, 5'b11111, 5'b00000), "R9");
    doCycle(0, 5'd0, 0, 2'd0, 2'd0, 0, 32'd0, "R10");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      doCycle(1'($urandom), 5'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
              ($urandom % 8) == 0, $urandom, "R7");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule